// File: doc/BRIEF.md
# Response Ring Write Engine

This block is the controller end of a response ring held in system memory. Responses of 64 bits arrive on a valid/ready input. The engine stores each one in the next ring slot through a single memory write port, and then moves forward a write pointer that only the hardware owns. Software keeps its own read position in memory. It drains entries until that position matches the hardware pointer, which it reads through the register port.

A small register port sets up the ring. It holds the base address, the ring size, a run bit, and an event threshold. After the programmed number of responses has been stored, a count event is raised. The engine has no knowledge of how far software has read. For that reason it reports an overrun when more responses have been stored since the last acknowledge than the ring can hold.

The engine is a three-state machine:
- `ENG_STOPPED`: the engine is idle.
- `ENG_ARMED`: the engine is running and waiting for a response.
- `ENG_STORING`: a memory write is pending.

The transitions are:
- START (STOPPED to ARMED): the run bit is set.
- HALT (ARMED to STOPPED): the run bit is clear.
- ACCEPT (ARMED to STORING): a response handshake takes place.
- RESUME (STORING to ARMED): the write completes and the run bit is still set.
- PARK (STORING to STOPPED): the write completes and the run bit is clear.

Top module: `rsp_ring_dma`

The register port uses 32-bit words selected by `reg_addr`. Each byte is written only when its lane in `reg_be` is set.

| Word | Byte offsets | Contents |
|------|--------------|----------|
| 0 | 0x0 | Base, low half |
| 1 | 0x4 | Base, high half |
| 2 | 0x8 / 0xA | Pointer in bits 15:0; event threshold in bits 23:16 |
| 3 | 0xC / 0xD / 0xE | Control in bits 7:0; status in bits 15:8; size in bits 23:16 |

## Requirements
- R1: After reset these all read 0: words 0 to 2, control, status, the pointer, `rsp_ready`, `mem_wvalid` and `irq`. Word 3 reads 0x0070_0000, because the size capability field (bits 22:20, size bits 6:4) reads 3'b111 for 2, 16 and 256 entries.
- R2: `rsp_ready` is high only in ENG_ARMED with the run bit set. It is low while the run bit is clear and while a memory write is pending.
- R3: An accepted response is written to slot (pointer+1) mod ring size. The write address is the aligned base plus 8 times the slot, and the data is the response unchanged. `mem_wvalid`, `mem_waddr` and `mem_wdata` hold steady until `mem_wready`.
- R4: The pointer (word 2, bits 7:0) takes the stored slot on the edge where `mem_wready` completes the write. It does not change otherwise.
- R5: Size select (word 3, bits 17:16) sets the ring size: 00 is 2 entries, 01 is 16, and 10 or 11 is 256.
- R6: Writing 1 to word 2 bit 15 clears the pointer to 0 and clears the response counter. Writes to word 2 bits 15:0 with bit 15 at 0 have no effect.
- R7: Bits 6:0 of the base low word are ignored and read back as 0.
- R8: Control bit 1 reads back whether the engine is running. It reads 1 from the cycle after run is set. After run is cleared it stays 1 until a pending write completes.
- R9: Status bit 0 (word 3 bit 8) is set when a stored response brings the response counter to the threshold (word 2 bits 23:16, where 0 means 256). `irq` equals status bit 0 AND control bit 0.
- R10: Writing 1 to status bit 0 clears the event and the response counter.
- R11: Status bit 2 (word 3 bit 10) is set when a response is stored while the counter already equals or exceeds the ring size. The write still takes place. Writing 1 to the bit clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_be | input | 4 | Byte lane enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response taken |
| rsp_data | input | DATA_W | Response payload |
| mem_wvalid | output | 1 | Memory write request |
| mem_wready | input | 1 | Memory write accepted |
| mem_waddr | output | 64 | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| irq | output | 1 | Count event interrupt |

## Verification
| Result | When it is due |
|--------|----------------|
| Memory request | Appears on the clock edge after the response handshake |
| Pointer, status bits and `irq` | Change on the edge where `mem_wready` is seen high |
| Register writes | Take effect on the edge that samples the strobe |
| Run-bit read-back | Follows one edge after the write that sets run |

The bench keeps a behavioural model that applies these same edges to its own integers. It compares the outputs at every falling clock edge. Inputs are driven just after rising edges, so each sample falls half a period after the edge that is meant to produce it.

// File: rtl/rsp_ring_pkg.sv
package rsp_ring_pkg;

    localparam int PTR_W  = 8;
    localparam int ADDR_W = 64;
    localparam int CNT_W  = PTR_W + 1;

    localparam logic [1:0] WORD_BASE_LO = 2'd0;
    localparam logic [1:0] WORD_BASE_HI = 2'd1;
    localparam logic [1:0] WORD_PTR     = 2'd2;
    localparam logic [1:0] WORD_CSR     = 2'd3;

    typedef enum logic [1:0] {
        ENG_STOPPED = 2'd0,
        ENG_ARMED   = 2'd1,
        ENG_STORING = 2'd2
    } eng_state_e;

    function automatic logic [PTR_W-1:0] slot_mask(input logic [1:0] sel);
        unique case (sel)
            2'b00:   slot_mask = PTR_W'(1);
            2'b01:   slot_mask = PTR_W'(15);
            default: slot_mask = {PTR_W{1'b1}};
        endcase
    endfunction

endpackage

// File: rtl/rsp_ring_regs.sv
module rsp_ring_regs
    import rsp_ring_pkg::*;
#(
    parameter logic [2:0] SIZE_CAP = 3'b111
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [1:0]             reg_addr,
    input  logic [3:0]             reg_be,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   eng_running,
    input  logic [PTR_W-1:0]       wp,
    input  logic                   cnt_flag,
    input  logic                   ovf_flag,
    output logic [ADDR_W-1:0]      base_addr,
    output logic                   run_req,
    output logic                   irq_en,
    output logic [7:0]             thresh,
    output logic [1:0]             size_sel,
    output logic                   ptr_rst,
    output logic                   evt_ack,
    output logic                   ovf_clr
);

    logic [31:7] base_lo_q;
    logic [31:0] base_hi_q;
    logic        hit_lo, hit_hi, hit_ptr, hit_csr;

    assign hit_lo  = reg_we && (reg_addr == WORD_BASE_LO);
    assign hit_hi  = reg_we && (reg_addr == WORD_BASE_HI);
    assign hit_ptr = reg_we && (reg_addr == WORD_PTR);
    assign hit_csr = reg_we && (reg_addr == WORD_CSR);

    assign ptr_rst = hit_ptr && reg_be[1] && reg_wdata[15];
    assign evt_ack = hit_csr && reg_be[1] && reg_wdata[8];
    assign ovf_clr = hit_csr && reg_be[1] && reg_wdata[10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            thresh    <= '0;
            run_req   <= 1'b0;
            irq_en    <= 1'b0;
            size_sel  <= 2'b00;
        end else begin
            if (hit_lo) begin
                if (reg_be[0]) base_lo_q[7]     <= reg_wdata[7];
                if (reg_be[1]) base_lo_q[15:8]  <= reg_wdata[15:8];
                if (reg_be[2]) base_lo_q[23:16] <= reg_wdata[23:16];
                if (reg_be[3]) base_lo_q[31:24] <= reg_wdata[31:24];
            end
            if (hit_hi) begin
                for (int b = 0; b < 4; b++) begin
                    if (reg_be[b]) base_hi_q[b*8 +: 8] <= reg_wdata[b*8 +: 8];
                end
            end
            if (hit_ptr && reg_be[2]) thresh <= reg_wdata[23:16];
            if (hit_csr && reg_be[0]) begin
                irq_en  <= reg_wdata[0];
                run_req <= reg_wdata[1];
            end
            if (hit_csr && reg_be[2]) size_sel <= reg_wdata[17:16];
        end
    end

    assign base_addr = {base_hi_q, base_lo_q, 7'b0};

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            WORD_BASE_LO: reg_rdata = {base_lo_q, 7'b0};
            WORD_BASE_HI: reg_rdata = base_hi_q;
            WORD_PTR:     reg_rdata = {8'h00, thresh, 8'h00, wp};
            WORD_CSR:     reg_rdata = {8'h00, 1'b0, SIZE_CAP, 2'b00, size_sel,
                                       5'b0, ovf_flag, 1'b0, cnt_flag,
                                       6'b0, eng_running, irq_en};
            default:      reg_rdata = '0;
        endcase
    end

    // R7: the low address bits of the base never reach the address output
    a_r7_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        base_addr[6:0] == 7'b0);

endmodule

// File: rtl/rsp_ring_engine.sv
module rsp_ring_engine
    import rsp_ring_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_req,
    input  logic               ptr_rst,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic [1:0]         size_sel,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [DATA_W-1:0]  rsp_data,
    output logic               mem_wvalid,
    input  logic               mem_wready,
    output logic [ADDR_W-1:0]  mem_waddr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [PTR_W-1:0]   wp,
    output logic               eng_running,
    output logic               commit
);

    localparam int STEP_SH = $clog2(DATA_W / 8);

    eng_state_e          state_q, state_d;
    logic [PTR_W-1:0]    wp_q, slot_q, slot_nxt;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic                accept;

    assign slot_nxt = (wp_q + PTR_W'(1)) & slot_mask(size_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_STOPPED: if (run_req) state_d = ENG_ARMED;
            ENG_ARMED: begin
                if (!run_req)       state_d = ENG_STOPPED;
                else if (rsp_valid) state_d = ENG_STORING;
            end
            ENG_STORING: begin
                if (mem_wready) state_d = run_req ? ENG_ARMED : ENG_STOPPED;
            end
            default: state_d = ENG_STOPPED;
        endcase
    end

    always_comb begin
        rsp_ready   = (state_q == ENG_ARMED) && run_req;
        mem_wvalid  = (state_q == ENG_STORING);
        eng_running = (state_q != ENG_STOPPED);
        accept      = rsp_ready && rsp_valid;
        commit      = mem_wvalid && mem_wready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q   <= '0;
            slot_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (accept) begin
                slot_q <= slot_nxt;
                addr_q <= base_addr + ({{(ADDR_W-PTR_W){1'b0}}, slot_nxt} << STEP_SH);
                data_q <= rsp_data;
            end
            if (ptr_rst)     wp_q <= '0;
            else if (commit) wp_q <= slot_q;
        end
    end

    assign wp        = wp_q;
    assign mem_waddr = addr_q;
    assign mem_wdata = data_q;

    a_r2_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ready |-> (run_req && !mem_wvalid));

    a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

    a_r3_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> (mem_waddr[STEP_SH-1:0] == '0));

    a_r4_ptr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !ptr_rst) |=> $stable(wp));

    a_r8_run_stop_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> eng_running);

endmodule

// File: rtl/rsp_ring_events.sv
module rsp_ring_events
    import rsp_ring_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  logic        evt_ack,
    input  logic        ovf_clr,
    input  logic        ptr_rst,
    input  logic [7:0]  thresh,
    input  logic [1:0]  size_sel,
    output logic        cnt_flag,
    output logic        ovf_flag
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << PTR_W);

    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_inc, limit, entries;
    logic             hit_set, ovf_set;

    assign cnt_base = (evt_ack || ptr_rst) ? '0 : cnt_q;
    assign cnt_inc  = (cnt_base == CNT_MAX) ? cnt_base : cnt_base + CNT_W'(1);
    assign limit    = (thresh == 8'd0) ? CNT_MAX : {1'b0, thresh};
    assign entries  = {1'b0, slot_mask(size_sel)} + CNT_W'(1);
    assign hit_set  = commit && ((cnt_base + CNT_W'(1)) == limit);
    assign ovf_set  = commit && (cnt_base >= entries);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cnt_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            cnt_q    <= commit ? cnt_inc : cnt_base;
            cnt_flag <= hit_set || (cnt_flag && !evt_ack);
            ovf_flag <= ovf_set || (ovf_flag && !ovf_clr);
        end
    end

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_flag && !evt_ack) |=> cnt_flag);

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_ack && !commit) |=> !cnt_flag);

    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    a_r11_ovf_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(commit));

endmodule

// File: rtl/rsp_ring_dma.sv
module rsp_ring_dma
    import rsp_ring_pkg::*;
#(
    parameter int         DATA_W   = 64,
    parameter logic [2:0] SIZE_CAP = 3'b111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [3:0]         reg_be,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [DATA_W-1:0]  rsp_data,
    output logic               mem_wvalid,
    input  logic               mem_wready,
    output logic [ADDR_W-1:0]  mem_waddr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               irq
);

    logic [ADDR_W-1:0] base_addr;
    logic [PTR_W-1:0]  wp;
    logic [7:0]        thresh;
    logic [1:0]        size_sel;
    logic              run_req, irq_en, ptr_rst, evt_ack, ovf_clr;
    logic              eng_running, commit, cnt_flag, ovf_flag;

    rsp_ring_regs #(.SIZE_CAP(SIZE_CAP)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_running(eng_running), .wp(wp),
        .cnt_flag(cnt_flag), .ovf_flag(ovf_flag),
        .base_addr(base_addr), .run_req(run_req), .irq_en(irq_en),
        .thresh(thresh), .size_sel(size_sel),
        .ptr_rst(ptr_rst), .evt_ack(evt_ack), .ovf_clr(ovf_clr)
    );

    rsp_ring_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .run_req(run_req), .ptr_rst(ptr_rst),
        .base_addr(base_addr), .size_sel(size_sel),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .wp(wp), .eng_running(eng_running), .commit(commit)
    );

    rsp_ring_events u_events (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .evt_ack(evt_ack), .ovf_clr(ovf_clr),
        .ptr_rst(ptr_rst), .thresh(thresh), .size_sel(size_sel),
        .cnt_flag(cnt_flag), .ovf_flag(ovf_flag)
    );

    assign irq = cnt_flag && irq_en;

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cnt_flag);

endmodule

// File: tb/sim_rsp_ring_dma.sv
module sim_rsp_ring_dma;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [63:0] rsp_data = '0;
    logic        mem_wvalid;
    logic        mem_wready = 1'b1;
    logic [63:0] mem_waddr;
    logic [63:0] mem_wdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rdy_mode = 0;
    bit model_live = 0;
    bit done = 0;

    rsp_ring_dma u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_state, m_wp, m_cnt, m_slot, m_thr, m_sel;
    bit          m_flag, m_ovf, m_run, m_ien;
    logic [31:0] m_lo, m_hi;
    logic [63:0] m_addr, m_data;

    function automatic int ents(input int s);
        return (s == 0) ? 2 : (s == 1) ? 16 : 256;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_wp = 0; m_cnt = 0; m_slot = 0; m_thr = 0; m_sel = 0;
            m_flag = 0; m_ovf = 0; m_run = 0; m_ien = 0;
            m_lo = 0; m_hi = 0; m_addr = 0; m_data = 0;
            model_live = 1;
        end else begin
            bit pr, ak, oc, cm;
            int b, lim, en;
            pr = reg_we && reg_addr == 2 && reg_be[1] && reg_wdata[15];
            ak = reg_we && reg_addr == 3 && reg_be[1] && reg_wdata[8];
            oc = reg_we && reg_addr == 3 && reg_be[1] && reg_wdata[10];
            cm = (m_state == 2) && mem_wready;
            en = ents(m_sel);
            lim = (m_thr == 0) ? 256 : m_thr;
            b = (ak || pr) ? 0 : m_cnt;
            if (cm) begin
                m_flag = (b + 1 == lim) || (m_flag && !ak);
                m_ovf  = (b >= en) || (m_ovf && !oc);
                m_cnt  = (b == 256) ? 256 : b + 1;
            end else begin
                m_flag = m_flag && !ak;
                m_ovf  = m_ovf && !oc;
                m_cnt  = b;
            end
            if (pr) m_wp = 0;
            else if (cm) m_wp = m_slot;
            case (m_state)
                0: if (m_run) m_state = 1;
                1: if (!m_run) m_state = 0;
                   else if (rsp_valid) begin
                       m_state = 2;
                       m_slot = (m_wp + 1) % en;
                       m_addr = {m_hi, m_lo[31:7], 7'b0} + 64'(m_slot) * 8;
                       m_data = rsp_data;
                   end
                default: if (mem_wready) m_state = m_run ? 1 : 0;
            endcase
            if (pr) m_wp = 0;
            if (reg_we) begin
                if (reg_addr == 0)
                    for (int k = 0; k < 4; k++) if (reg_be[k]) m_lo[k*8 +: 8] = reg_wdata[k*8 +: 8];
                if (reg_addr == 1)
                    for (int k = 0; k < 4; k++) if (reg_be[k]) m_hi[k*8 +: 8] = reg_wdata[k*8 +: 8];
                if (reg_addr == 2 && reg_be[2]) m_thr = int'(reg_wdata[23:16]);
                if (reg_addr == 3 && reg_be[0]) begin
                    m_ien = reg_wdata[0];
                    m_run = reg_wdata[1];
                end
                if (reg_addr == 3 && reg_be[2]) m_sel = int'(reg_wdata[17:16]);
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && model_live && !done) begin
            check("R2 rsp_ready", 64'(rsp_ready), 64'(m_state == 1 && m_run));
            check("R3 mem_wvalid", 64'(mem_wvalid), 64'(m_state == 2));
            if (m_state == 2) begin
                check("R3 mem_waddr", mem_waddr, m_addr);
                check("R3 mem_wdata", mem_wdata, m_data);
            end
            check("R9 irq", 64'(irq), 64'(m_flag && m_ien));
        end
    end

    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0: mem_wready = 1'b1;
            1: mem_wready = ~mem_wready;
            default: mem_wready = 1'b0;
        endcase
    end

    task automatic reg_write(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = w; reg_be = be; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_be = '0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] w, output logic [31:0] v);
        @(posedge clk); #1;
        reg_addr = w;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic send(input logic [63:0] d);
        @(posedge clk); #1;
        rsp_valid = 1'b1; rsp_data = d;
        do @(negedge clk); while (!rsp_ready);
        @(posedge clk); #1;
        rsp_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (mem_wvalid) @(negedge clk);
    endtask

    task automatic send_n(input int n, input logic [63:0] tag);
        for (int i = 0; i < n; i++) begin
            send(tag + 64'(i));
            wait_done();
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 rsp_ready", 64'(rsp_ready), 0);
        check("R1 mem_wvalid", 64'(mem_wvalid), 0);
        check("R1 irq", 64'(irq), 0);
        reg_read(0, v); check("R1 base lo", 64'(v), 0);
        reg_read(1, v); check("R1 base hi", 64'(v), 0);
        reg_read(2, v); check("R1 pointer word", 64'(v), 0);
        reg_read(3, v); check("R1 csr word", 64'(v), 64'h0070_0000);

        // R7 base alignment
        reg_write(0, 4'hF, 32'h9ABC_DEFF);
        reg_write(1, 4'hF, 32'h1234_5678);
        reg_read(0, v); check("R7 base low masked", 64'(v), 64'h9ABC_DE80);

        reg_write(2, 4'b0100, 32'h0003_0000);
        reg_write(3, 4'b0100, 32'h0001_0000);
        reg_write(3, 4'b0001, 32'h0000_0003);
        reg_read(3, v); check("R8 running after start", 64'(v), 64'h0071_0003);

        // R4 / R9: five responses with a toggling memory ready
        rdy_mode = 1;
        send_n(5, 64'hA5A5_0000_0000_0000);
        reg_read(2, v); check("R4 pointer after five", 64'(v), 64'h0003_0005);
        check("R9 irq after threshold", 64'(irq), 1);
        reg_read(3, v); check("R9 status event", 64'(v), 64'h0071_0103);

        // R3 stalled write: slot 6 address and data held
        rdy_mode = 2;
        send(64'hDEAD_BEEF_0123_4567);
        repeat (3) @(negedge clk);
        check("R3 slot address", mem_waddr, 64'h1234_5678_9ABC_DE80 + 64'd48);
        check("R3 slot data", mem_wdata, 64'hDEAD_BEEF_0123_4567);
        check("R2 ready low while pending", 64'(rsp_ready), 0);
        rdy_mode = 0;
        wait_done();
        reg_read(2, v); check("R4 pointer six", 64'(v), 64'h0003_0006);

        // R6 write without reset bit ignored
        reg_write(2, 4'b0011, 32'h0000_00AB);
        reg_read(2, v); check("R6 plain write ignored", 64'(v), 64'h0003_0006);

        // R10 acknowledge clears event and counter
        reg_write(3, 4'b0010, 32'h0000_0100);
        @(negedge clk); check("R10 irq cleared", 64'(irq), 0);
        send_n(2, 64'h1000);
        check("R10 no event after two", 64'(irq), 0);
        send_n(1, 64'h2000);
        check("R10 event after recount", 64'(irq), 1);
        reg_write(3, 4'b0010, 32'h0000_0100);

        // R5 / R11: two-entry ring overrun
        reg_write(3, 4'b0100, 32'h0000_0000);
        send_n(2, 64'h3000);
        reg_read(2, v); check("R5 two-entry wrap", 64'(v), 64'h0003_0001);
        reg_read(3, v); check("R11 no overrun yet", 64'(v), 64'h0070_0003);
        send_n(1, 64'h4000);
        reg_read(2, v); check("R5 pointer wraps to 0", 64'(v), 64'h0003_0000);
        reg_read(3, v); check("R11 overrun set", 64'(v), 64'h0070_0503);
        reg_write(3, 4'b0010, 32'h0000_0400);
        reg_read(3, v); check("R11 overrun cleared", 64'(v), 64'h0070_0103);
        reg_write(3, 4'b0010, 32'h0000_0100);

        // R6 pointer reset
        send_n(1, 64'h5000);
        reg_read(2, v); check("R6 pointer before reset", 64'(v), 64'h0003_0001);
        reg_write(2, 4'b0010, 32'h0000_8000);
        reg_read(2, v); check("R6 pointer reset", 64'(v), 64'h0003_0000);

        // R8 stop waits for pending write
        rdy_mode = 2;
        send(64'h6000);
        reg_write(3, 4'b0001, 32'h0000_0001);
        reg_read(3, v); check("R8 still running while pending", 64'(v & 32'h0000_0002), 64'h2);
        check("R2 ready low with run clear", 64'(rsp_ready), 0);
        rdy_mode = 0;
        wait_done();
        reg_read(3, v); check("R8 stopped after write", 64'(v & 32'h0000_0002), 0);
        reg_write(3, 4'b0001, 32'h0000_0003);

        // R5 / R9 / R11: 256-entry ring, threshold 0 means 256
        reg_write(3, 4'b0010, 32'h0000_0500);
        reg_write(2, 4'b0100, 32'h0000_0000);
        reg_write(3, 4'b0100, 32'h0002_0000);
        reg_write(2, 4'b0010, 32'h0000_8000);
        send_n(255, 64'h7000_0000);
        check("R9 no event at 255", 64'(irq), 0);
        reg_read(2, v); check("R5 pointer 255", 64'(v), 64'h0000_00FF);
        send_n(1, 64'h8000);
        check("R9 event at 256", 64'(irq), 1);
        reg_read(2, v); check("R5 256 wrap", 64'(v), 64'h0000_0000);
        reg_read(3, v); check("R11 full lap no overrun", 64'(v), 64'h0072_0103);
        send_n(1, 64'h9000);
        reg_read(3, v); check("R11 lap overrun", 64'(v), 64'h0072_0503);
        reg_write(3, 4'b0100, 32'h0003_0000);
        send_n(1, 64'hA000);
        reg_read(2, v); check("R5 select 11 is 256", 64'(v), 64'h0000_0002);

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule